// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-mapped watchdog. A fixed clock divider turns the input clock into a one-microsecond base tick. A software-programmed prescaler turns base ticks into watchdog ticks. A down-counter of watchdog ticks requests a system reset when it runs out. Software keeps the system alive by writing a restart command before the count expires. The command reloads the counter from a load register and clears both dividers.

Software programs the block with 32-bit word writes and reads it with 32-bit word reads. The block has three register words and one cause word:

- **Kick word:** accepts the restart command.
- **Control word:** holds the run enable and the prescale divisor.
- **Load word:** holds the timeout in watchdog ticks.
- **Cause word:** holds a sticky flag that records the watchdog as the source of the last reset. The flag survives the chip reset that the block itself provokes. Only a power-on reset or a write-one-to-clear removes it.

Software reprograms the block in three steps: disable, rewrite the divisor and the load, then re-enable. Re-enabling always restarts the count from the load value, so no expiry occurs part-way through the sequence.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, `rstReq` is low, the control word (offset 0x20) reads 0, the load word (offset 0x24) reads 0x0000FFFF and the cause word (offset 0x38) reads 0.
- R2: Control bit 7 is the run enable and bits 31:16 are the divisor D (0 acts as 1). Load bits 15:0 are the load L. The write that sets bit 7 while the enable is off is taken at clock edge E. With C clocks per microsecond, `rstReq` first goes high right after edge E + L*D*C + 1.
- R3: A write to offset 0x00 with bit 9 set, taken at edge K, reloads the count from the load word and clears both dividers. The next rise of `rstReq` moves to just after edge K + L*D*C + 1.
- R4: A write to the load word does not change the count already running. The new value is used from the next restart, enable or expiry reload.
- R5: While bit 7 is clear, the count and the prescaler hold, and no new reset request starts. Bit 7 reads back the current enable.
- R6: Each reset request stays high for exactly RST_CYCLES clock cycles. The expiry edge also reloads the count from the load word. While the block stays enabled, the next request therefore follows L*D*C + 1 cycles after the previous rise.
- R7: Expiry sets bit 1 of the cause word. The bit stays set through `sysRstN` and clears only on `porRstN` or on a write to offset 0x38 with bit 1 set.
- R8: Asserting `sysRstN` returns the control word, the load word and `rstReq` to their reset values.
- R9: A read at an unmapped offset returns 0, and a write there changes no register and starts no restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| porRstN | input | 1 | Power-on reset, active low, clears everything |
| sysRstN | input | 1 | Chip reset, active low, spares the cause flag |
| wrEn | input | 1 | Word write strobe |
| rdEn | input | 1 | Word read strobe |
| addr | input | 8 | Byte offset of the accessed word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational, zero when rdEn is low |
| rstReq | output | 1 | System reset request |

## Verification
A wrong divider or counter state shows up as a rise of `rstReq` on the wrong cycle. The mismatch is seen at the first expiry, at most L*D*C + 1 cycles after the last restart. The bench therefore predicts the exact rise cycle of every request and the exact width of every pulse. A lost or spurious restart moves or adds a rise. A wrong cause flag is seen on the next read of the cause word, which the bench performs after expiry, across a chip reset, and after both kinds of clear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_KICK  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_LOAD  = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_CAUSE = 8'h38;

  localparam int KICK_BIT  = 9;
  localparam int EN_BIT    = 7;
  localparam int DIV_LSB   = 16;
  localparam int CAUSE_BIT = 1;

  typedef struct packed {
    logic restart;
    logic run;
  } wdStrobes_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int LOAD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porRstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expireEv,
  output logic [DATA_W-1:0] rdData,
  output wdStrobes_t        strb,
  output logic [DIV_W-1:0]  divisor,
  output logic [LOAD_W-1:0] loadVal
);
  localparam logic [LOAD_W-1:0] LOAD_RST = '1;

  logic enReg;
  logic [DIV_W-1:0] divReg;
  logic [LOAD_W-1:0] loadReg;
  logic causeReg;

  logic selKick, selCtrl, selLoad, selCause;
  logic wrCtrl, wrLoad, kickCmd, enableCmd, causeClr;

  assign selKick  = (addr == OFF_KICK);
  assign selCtrl  = (addr == OFF_CTRL);
  assign selLoad  = (addr == OFF_LOAD);
  assign selCause = (addr == OFF_CAUSE);

  assign wrCtrl    = wrEn && selCtrl;
  assign wrLoad    = wrEn && selLoad;
  assign kickCmd   = wrEn && selKick && wrData[KICK_BIT];
  assign enableCmd = wrCtrl && wrData[EN_BIT] && !enReg;
  assign causeClr  = wrEn && selCause && wrData[CAUSE_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      divReg  <= '0;
      loadReg <= LOAD_RST;
    end else begin
      if (wrCtrl) begin
        enReg  <= wrData[EN_BIT];
        divReg <= wrData[DIV_LSB +: DIV_W];
      end
      if (wrLoad) loadReg <= wrData[LOAD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) causeReg <= 1'b0;
    else if (expireEv) causeReg <= 1'b1;
    else if (causeClr) causeReg <= 1'b0;
  end

  always_comb begin
    strb.restart = kickCmd || enableCmd;
    strb.run     = enReg;
  end

  assign divisor = divReg;
  assign loadVal = loadReg;

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (1'b1)
        selCtrl: begin
          rdData[EN_BIT] = enReg;
          rdData[DIV_LSB +: DIV_W] = divReg;
        end
        selLoad:  rdData[LOAD_W-1:0] = loadReg;
        selCause: rdData[CAUSE_BIT] = causeReg;
        default:  rdData = '0;
      endcase
    end
  end

  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!porRstN)
    expireEv |=> causeReg); // R7
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!porRstN)
    (causeReg && !causeClr) |=> causeReg); // R7
  AST_ENABLE_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enReg) |-> $past(strb.restart)); // R5
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CLKS_PER_US = 250,
  parameter int DIV_W       = 16,
  parameter int LOAD_W      = 16,
  parameter int RST_CYCLES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdStrobes_t        strb,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [LOAD_W-1:0] loadVal,
  output logic              expireEv,
  output logic              rstReq
);
  localparam int BASE_W  = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam int PULSE_W = $clog2(RST_CYCLES + 1);
  localparam logic [PULSE_W-1:0] PULSE_LAST = PULSE_W'(RST_CYCLES - 1);

  logic baseTick, wdTick, reloadNow;
  logic [DIV_W-1:0] preCnt, divEff;
  logic [LOAD_W-1:0] count;
  logic [PULSE_W-1:0] pulseLeft;

  assign reloadNow = strb.restart || expireEv;

  generate
    if (CLKS_PER_US == 1) begin : g_noBaseDiv
      assign baseTick = strb.run;
    end else begin : g_baseDiv
      logic [BASE_W-1:0] baseCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) baseCnt <= '0;
        else if (reloadNow) baseCnt <= '0;
        else if (strb.run) baseCnt <= baseTick ? '0 : baseCnt + 1'b1;
      end
      assign baseTick = strb.run && (baseCnt == BASE_W'(CLKS_PER_US - 1));
    end
  endgenerate

  assign divEff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign wdTick = baseTick && (preCnt == divEff - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (reloadNow) preCnt <= '0;
    else if (baseTick) preCnt <= wdTick ? '0 : preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (reloadNow) count <= loadVal;
    else if (wdTick && count != '0) count <= count - 1'b1;
  end

  assign expireEv = strb.run && (count == '0) && !rstReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq    <= 1'b0;
      pulseLeft <= '0;
    end else if (expireEv) begin
      rstReq    <= 1'b1;
      pulseLeft <= PULSE_LAST;
    end else if (rstReq) begin
      if (pulseLeft == '0) rstReq <= 1'b0;
      else pulseLeft <= pulseLeft - 1'b1;
    end
  end

  logic [PULSE_W:0] seenLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenLen <= '0;
    else if (rstReq) seenLen <= seenLen + 1'b1;
    else seenLen <= '0;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstReq) |-> (seenLen == (PULSE_W+1)'(RST_CYCLES))); // R6
  AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (count == $past(loadVal))); // R3
  AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> $past(strb.run)); // R5
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.restart) |=> ($stable(count) && $stable(preCnt))); // R5
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CLKS_PER_US = 250,
  parameter int DIV_W       = 16,
  parameter int LOAD_W      = 16,
  parameter int RST_CYCLES  = 16
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rstReq
);
  logic coreRstN;
  logic expireEv;
  wdStrobes_t strb;
  logic [DIV_W-1:0] divisor;
  logic [LOAD_W-1:0] loadVal;

  assign coreRstN = porRstN && sysRstN;

  wdog_ctrl #(.DIV_W(DIV_W), .LOAD_W(LOAD_W)) u_ctrl (
    .clk(clk), .rstN(coreRstN), .porRstN(porRstN),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .expireEv(expireEv), .rdData(rdData), .strb(strb),
    .divisor(divisor), .loadVal(loadVal)
  );

  wdog_datapath #(.CLKS_PER_US(CLKS_PER_US), .DIV_W(DIV_W),
                  .LOAD_W(LOAD_W), .RST_CYCLES(RST_CYCLES)) u_dp (
    .clk(clk), .rstN(coreRstN), .strb(strb), .divisor(divisor),
    .loadVal(loadVal), .expireEv(expireEv), .rstReq(rstReq)
  );
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int C = 4;
  localparam int P = 5;

  logic clk = 0, porRstN = 0, sysRstN = 0, wrEn = 0, rdEn = 0;
  logic [7:0] addr = 0;
  logic [31:0] wrData = 0, rdData;
  logic rstReq;

  int cyc = 0, checks = 0, errors = 0;
  int expQ[$];
  bit done = 0;
  bit prevReq = 0;
  int highLen = 0;

  wdog_timer #(.CLKS_PER_US(C), .RST_CYCLES(P)) u_wdog_timer (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rstReq(rstReq));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, output int edgeN);
    @(negedge clk);
    wrEn = 1; addr = a; wrData = d;
    edgeN = cyc + 1;
    @(negedge clk);
    wrEn = 0; wrData = 0; addr = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1; addr = a;
    #1 d = rdData;
    rdEn = 0; addr = 0;
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops expected request rise cycles, checks pulse width
  always @(negedge clk) begin
    if (porRstN && sysRstN) begin
      if (rstReq && !prevReq) begin
        if (expQ.size() == 0) check(0, "R6 unexpected request", 32'(cyc), 0);
        else begin
          int e;
          e = expQ.pop_front();
          check(cyc == e, "R2 request rise cycle", 32'(cyc), 32'(e));
        end
        highLen = 1;
      end else if (rstReq) highLen++;
      else if (prevReq) check(highLen == P, "R6 request width", 32'(highLen), 32'(P));
    end
    prevReq = rstReq;
  end

  initial begin
    int e, e2, k, dummy;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    porRstN = 1; sysRstN = 1;
    @(negedge clk);

    // R1 reset state
    check(rstReq == 0, "R1 rstReq", 32'(rstReq), 0);
    busRead(8'h20, d); check(d == 0, "R1 ctrl", d, 0);
    busRead(8'h24, d); check(d == 32'h0000FFFF, "R1 load", d, 32'h0000FFFF);
    busRead(8'h38, d); check(d == 0, "R1 cause", d, 0);

    // R9 unmapped offsets
    busRead(8'h10, d); check(d == 0, "R9 unmapped read", d, 0);
    busWrite(8'h10, 32'hFFFFFFFF, dummy);
    busWrite(8'h04, 32'hFFFFFFFF, dummy);
    busRead(8'h20, d); check(d == 0, "R9 ctrl untouched", d, 0);
    busRead(8'h24, d); check(d == 32'h0000FFFF, "R9 load untouched", d, 32'h0000FFFF);

    // R2 / R6 basic expiry and auto reload
    busWrite(8'h24, 3, dummy);
    busWrite(8'h20, (32'd2 << 16) | 32'h80, e);
    expQ.push_back(e + 3*2*C + 1);
    expQ.push_back(e + 2*(3*2*C + 1));
    busRead(8'h20, d); check(d == 32'h00020080, "R5 ctrl readback", d, 32'h00020080);
    waitUntil(e + 3*2*C + 2);
    busRead(8'h38, d); check(d == 32'h2, "R7 cause set", d, 32'h2);
    waitUntil(e + 60);
    busWrite(8'h20, 32'h00020000, dummy);
    waitUntil(e + 120);
    check(expQ.size() == 0, "R6 second request seen", 32'(expQ.size()), 0);

    // R7 write-one-to-clear
    busWrite(8'h38, 32'h2, dummy);
    busRead(8'h38, d); check(d == 0, "R7 cause cleared", d, 0);

    // R3 kick, R4 load write does not touch running count
    busWrite(8'h24, 4, dummy);
    busWrite(8'h20, (32'd1 << 16) | 32'h80, e);
    waitUntil(e + 8);
    busWrite(8'h00, 32'h200, k);
    expQ.push_back(k + 4*C + 1);
    busWrite(8'h24, 7, dummy);
    expQ.push_back(k + 4*C + 1 + 7*C + 1);
    waitUntil(k + 4*C + 1 + 7*C + 5);
    check(expQ.size() == 0, "R4 reload used new load", 32'(expQ.size()), 0);
    busWrite(8'h20, 32'h00010000, dummy);
    busRead(8'h24, d); check(d == 7, "R4 load readback", d, 7);

    // R5 disable holds, reprogram, re-enable restarts
    busWrite(8'h24, 5, dummy);
    busWrite(8'h20, (32'd1 << 16) | 32'h80, e);
    waitUntil(e + 10);
    busWrite(8'h20, 32'h00010000, dummy);
    waitUntil(e + 110);
    busRead(8'h20, d); check(d[7] == 0, "R5 enable reads off", d, 32'h00010000);
    busWrite(8'h20, 32'h00020000, dummy);
    busWrite(8'h24, 2, dummy);
    busWrite(8'h20, (32'd2 << 16) | 32'h80, e2);
    expQ.push_back(e2 + 2*2*C + 1);
    waitUntil(e2 + 2*2*C + 1 + P + 3);
    check(expQ.size() == 0, "R5 re-enable expiry seen", 32'(expQ.size()), 0);

    // R8 chip reset spares the cause flag
    @(negedge clk); sysRstN = 0;
    repeat (3) @(negedge clk);
    check(rstReq == 0, "R8 rstReq in chip reset", 32'(rstReq), 0);
    sysRstN = 1;
    busRead(8'h20, d); check(d == 0, "R8 ctrl reset", d, 0);
    busRead(8'h24, d); check(d == 32'h0000FFFF, "R8 load reset", d, 32'h0000FFFF);
    busRead(8'h38, d); check(d == 32'h2, "R7 cause survives chip reset", d, 32'h2);
    @(negedge clk); porRstN = 0;
    @(negedge clk); porRstN = 1;
    busRead(8'h38, d); check(d == 0, "R7 cause cleared by power-on", d, 0);

    // R2 boundary: load zero expires one cycle after enable
    busWrite(8'h24, 0, dummy);
    busWrite(8'h20, (32'd3 << 16) | 32'h80, e);
    expQ.push_back(e + 1);
    busWrite(8'h20, 0, dummy);
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R2 zero load expiry", 32'(expQ.size()), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule